// File: doc/BRIEF.md
# Interrupt Event Aggregator with Keyed Soft Reset

This block collects eight event lines from an I2C master engine and turns them into one interrupt request. Each event sets a sticky bit in a status register. Software clears a bit by writing a one to it. An enable register chooses which sticky bits may raise the interrupt. A single global enable bit then gates the combined request onto the output line.

The same register port also carries a soft-reset register. Writing the key value to it clears the status, enable and global-enable state. It also sends a one-cycle reset pulse to the attached engine. Any other value written there is ignored.

Reads are combinational from the address. Writes take effect on the rising clock edge at which `bus_wr` is high.

Top module: `irq_aggregator`

## Requirements
- R1: After hardware reset (`rst_n` low), the following all read as zero: status (offset 0x20), enable (offset 0x28) and global enable (offset 0x1C). `irq` and `core_rst_pulse` are low.
- R2: An event input that is high at a clock edge sets the status bit of the same index. The bit stays set after the event goes low. The bit indices are: 0 arbitration lost, 1 transmit error or done, 2 transmit FIFO empty, 3 receive threshold reached, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit FIFO half empty.
- R3: Writing offset 0x20 clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero keep their value.
- R4: If an event input is high in the same cycle as a clear of its bit, the bit stays set.
- R5: The enable register at offset 0x28 (bits 7:0) reads back what was written. `irq` is high only when some bit is set in both status and enable, and global enable is set.
- R6: Global enable is bit 31 of offset 0x1C. It reads back in bit 31, and all other bits of that offset read zero.
- R7: Writing exactly 0x0000000A to offset 0x40 raises `core_rst_pulse` for exactly one cycle, the cycle after the write edge.
- R8: A key write to offset 0x40 clears status, enable and global enable. This holds even when events are high in that same cycle.
- R9: Writing any value other than the key to offset 0x40 gives no pulse and changes no register.
- R10: Reads from unmapped offsets, and from offset 0x40, return zero. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| event_in | input | 8 | Event lines from the engine |
| irq | output | 1 | Combined interrupt request |
| core_rst_pulse | output | 1 | One-cycle reset to the engine |

## Verification
A wrong sticky bit shows up on `bus_rdata` at the status offset in the cycle right after the edge that set or cleared it. If that bit is enabled, it also shows on `irq` in that same cycle. A wrong key comparison shows up one cycle after the write, as either a missing or an extra `core_rst_pulse`. It also shows as enable and global-enable values that should or should not have been wiped. The vectors place an event and a clear in the same cycle, and a key write and an event in the same cycle, because those two collisions decide which update wins.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int GIE_BIT = 31,
  parameter logic [ADDR_W-1:0] OFS_GIE = 8'h1C,
  parameter logic [ADDR_W-1:0] OFS_STS = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENA = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_RST = 8'h40,
  parameter logic [DATA_W-1:0] RESET_KEY = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] event_in,
  output logic              irq,
  output logic              core_rst_pulse
);

  logic [NUM_SRC-1:0] status_q, enable_q;
  logic gie_q, pulse_q;

  wire wr_gie = bus_wr && (bus_addr == OFS_GIE);
  wire wr_sts = bus_wr && (bus_addr == OFS_STS);
  wire wr_ena = bus_wr && (bus_addr == OFS_ENA);
  wire key_hit = bus_wr && (bus_addr == OFS_RST) && (bus_wdata == RESET_KEY);

  wire [NUM_SRC-1:0] clr_mask = wr_sts ? bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      gie_q    <= 1'b0;
    end else if (key_hit) begin
      status_q <= '0;
      enable_q <= '0;
      gie_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | event_in;
      if (wr_ena) enable_q <= bus_wdata[NUM_SRC-1:0];
      if (wr_gie) gie_q <= bus_wdata[GIE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= key_hit;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_GIE: bus_rdata[GIE_BIT] = gie_q;
      OFS_STS: bus_rdata[NUM_SRC-1:0] = status_q;
      OFS_ENA: bus_rdata[NUM_SRC-1:0] = enable_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = gie_q & (|(status_q & enable_q));
  assign core_rst_pulse = pulse_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_STS = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_RST = 8'h40,
  parameter logic [DATA_W-1:0] RESET_KEY = 32'h0000_000A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] event_in,
  input logic              irq,
  input logic              core_rst_pulse,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic              gie
);

  logic key_w, sts_w;
  assign key_w = bus_wr && bus_addr == OFS_RST && bus_wdata == RESET_KEY;
  assign sts_w = bus_wr && bus_addr == OFS_STS;

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !key_w |=> ((status & $past(event_in)) == $past(event_in)));

  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w && !key_w) |=> ((status & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(event_in)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && event_in == '0) |=> $stable(status));

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && (status & enable) != '0));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_pulse |=> !core_rst_pulse);

  p_pulse_follows_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_w |=> core_rst_pulse);

  p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_w |=> (status == '0 && enable == '0 && !gie));

  p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_w |=> !core_rst_pulse);

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_STS(OFS_STS), .OFS_RST(OFS_RST), .RESET_KEY(RESET_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .event_in(event_in), .irq(irq),
  .core_rst_pulse(core_rst_pulse), .status(status_q), .enable(enable_q),
  .gie(gie_q)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [7:0]  ev;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic        irq;
    logic        pulse;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  1'b1, 8'h28, 32'h0000_000F, 8'h00, 8'h28, 32'h0000_000F, 1'b0, 1'b0}, // R5 enable readback
    '{4'd2,  1'b0, 8'h00, 32'h0,         8'h05, 8'h20, 32'h0000_0005, 1'b0, 1'b0}, // R2 latch, no gie
    '{4'd6,  1'b1, 8'h1C, 32'h8000_0000, 8'h00, 8'h1C, 32'h8000_0000, 1'b1, 1'b0}, // R6 gie on, irq
    '{4'd3,  1'b1, 8'h20, 32'h0000_0004, 8'h00, 8'h20, 32'h0000_0001, 1'b1, 1'b0}, // R3 w1c bit2
    '{4'd4,  1'b1, 8'h20, 32'h0000_0001, 8'h01, 8'h20, 32'h0000_0001, 1'b1, 1'b0}, // R4 event wins
    '{4'd3,  1'b1, 8'h20, 32'h0000_0001, 8'h00, 8'h20, 32'h0000_0000, 1'b0, 1'b0}, // R3 clear
    '{4'd5,  1'b0, 8'h00, 32'h0,         8'h80, 8'h20, 32'h0000_0080, 1'b0, 1'b0}, // R5 masked
    '{4'd5,  1'b1, 8'h28, 32'h0000_0080, 8'h00, 8'h20, 32'h0000_0080, 1'b1, 1'b0}, // R5 unmask
    '{4'd3,  1'b1, 8'h20, 32'h0000_0000, 8'h00, 8'h20, 32'h0000_0080, 1'b1, 1'b0}, // R3 zero keeps
    '{4'd6,  1'b1, 8'h1C, 32'h7FFF_FFFF, 8'h00, 8'h1C, 32'h0000_0000, 1'b0, 1'b0}, // R6 only bit31
    '{4'd6,  1'b1, 8'h1C, 32'hFFFF_FFFF, 8'h00, 8'h1C, 32'h8000_0000, 1'b1, 1'b0}, // R6 others zero
    '{4'd9,  1'b1, 8'h40, 32'h0000_0005, 8'h00, 8'h28, 32'h0000_0080, 1'b1, 1'b0}, // R9 bad key
    '{4'd9,  1'b1, 8'h40, 32'h0000_001A, 8'h00, 8'h20, 32'h0000_0080, 1'b1, 1'b0}, // R9 upper bits
    '{4'd10, 1'b1, 8'h30, 32'hFFFF_FFFF, 8'h00, 8'h30, 32'h0000_0000, 1'b1, 1'b0}, // R10 unmapped
    '{4'd10, 1'b0, 8'h00, 32'h0,         8'h00, 8'h40, 32'h0000_0000, 1'b1, 1'b0}, // R10 reset reg reads 0
    '{4'd8,  1'b1, 8'h40, 32'h0000_000A, 8'hFF, 8'h20, 32'h0000_0000, 1'b0, 1'b1}, // R8 R7 key + events
    '{4'd7,  1'b0, 8'h00, 32'h0,         8'h00, 8'h1C, 32'h0000_0000, 1'b0, 1'b0}  // R7 single pulse
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] event_in = '0;
  logic irq, core_rst_pulse;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_in(event_in),
    .irq(irq), .core_rst_pulse(core_rst_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] ev, input logic [7:0] ra);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; event_in = ev;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; event_in = '0; bus_addr = ra;
    #0.5;
  endtask

  task automatic peek(input logic [7:0] ra);
    bus_addr = ra;
    #0.2;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    peek(8'h20); chk("R1 status after reset", bus_rdata, 32'h0);
    peek(8'h28); chk("R1 enable after reset", bus_rdata, 32'h0);
    peek(8'h1C); chk("R1 gie after reset", bus_rdata, 32'h0);
    chk("R1 irq/pulse after reset", {30'h0, irq, core_rst_pulse}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].ev, VEC[i].ra);
      chk($sformatf("R%0d vec %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp);
      chk($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'h0, irq}, {31'h0, VEC[i].irq});
      chk($sformatf("R%0d vec %0d pulse", VEC[i].req, i), {31'h0, core_rst_pulse}, {31'h0, VEC[i].pulse});
    end

    // R8 enable wiped by key (enable was 0x80 before the key write)
    peek(8'h28); chk("R8 enable after key", bus_rdata, 32'h0);

    // R2 every source index latches in its own bit
    for (int b = 0; b < 8; b++) begin
      cycle(1'b0, 8'h00, 32'h0, 8'(1 << b), 8'h20);
      chk($sformatf("R2 source %0d latch", b), bus_rdata, 32'(1 << b));
      cycle(1'b1, 8'h20, 32'hFF, 8'h00, 8'h20);
    end

    // R1 hardware reset mid-operation
    cycle(1'b1, 8'h28, 32'hFF, 8'h3C, 8'h20);
    cycle(1'b1, 8'h1C, 32'h8000_0000, 8'h00, 8'h20);
    chk("R5 irq before hw reset", {31'h0, irq}, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    peek(8'h20); chk("R1 status hw reset", bus_rdata, 32'h0);
    peek(8'h28); chk("R1 enable hw reset", bus_rdata, 32'h0);
    peek(8'h1C); chk("R1 gie hw reset", bus_rdata, 32'h0);
    chk("R1 irq hw reset", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule